// File: doc/BRIEF.md
# Five-Channel DC-Blocking High-Pass Filter Bank

This block removes DC offset and very low-frequency content from five audio channels in parallel. Each channel is a first-order recursive high-pass section with its own 11-bit coefficient and its own enable bit. All five channels receive one signed sample per input strobe. After one clock, all five filtered results appear together with an output strobe.

Software programs the bank through a byte-wide write port and can read the registers back through a combinational read port. Each coefficient is split across a pair of adjacent addresses: an upper byte and a 3-bit low part. The full value reaches the filter only when the low part is written. A channel that is disabled passes its input through unchanged and forgets its history.

The design has no control state machine. The only sequencing is the two-step coefficient commit and the one-cycle sample pipeline. Both are described below as register behaviour.

Top module: `hpf_bank`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is all zeros, every coefficient and enable register reads back 0, and every channel is disabled.
- R2: Channel n's upper coefficient byte is at address 0xB3+2n and its low part, in data bits [2:0], is at 0xB4+2n. The enable byte is at 0xBD, and bit n enables channel n. Writes to any other address change nothing, and reads of any other address return 0.
- R3: Bits [7:3] of a low-part register and bits [7:5] of the enable register are dropped on write and read back as 0.
- R4: Writing an upper byte only stages it. The channel's active coefficient becomes {staged upper byte, low 3 bits} when the low part is written, and it is used from the next sample on.
- R5: For an enabled channel with active code c (a = c/2048), input x, previous input xp and previous output yp, the output is floor(((2048+c)·(x−xp) + 2c·yp + 2048) / 4096). This is ((1+a)/2)(x−xp) + a·yp, rounded half up.
- R6: The filter result saturates to the signed 24-bit range [−8388608, 8388607] instead of wrapping, and the saturated value is the one kept as yp.
- R7: A disabled channel outputs its input sample unchanged, and its xp and yp are held at zero. After re-enabling, it starts from zero history.
- R8: `out_valid` follows `in_valid` by exactly one clock. `out_data` changes only in the cycle after an input strobe and holds otherwise.
- R9: Channels are independent. Each one uses only its own coefficient, enable bit and sample slice, found at bits [24n+23:24n].
- R10: With code 1820 (0x71C, cutoff about 900 Hz at 48 kHz) and a constant input of 1000000, the first output is 944336. The output then decays to within ±8 of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 8 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| in_valid | input | 1 | Input sample strobe for all channels |
| in_data | input | 120 | Five signed 24-bit samples, channel n at [24n+23:24n] |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_data | output | 120 | Five signed 24-bit filtered samples, same packing |

## Verification
The bench builds the bank with its default parameters: five channels, 24-bit samples, 11-bit coefficients, and a register base of 0xB3. With 24-bit samples, a full-scale negative-to-positive step reaches the positive saturation limit. The 11-bit code lets the 0x71C design point and the extreme code 2047 be driven. With five channels, three spare enable bits exist, so the padding rule can be exercised. Random coefficient writes, enable changes, and samples with gaps between strobes run against a bench model of the rounding formula. Directed cases cover the commit order, bypass, saturation and DC decay.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
    localparam int SAMPLE_W = 24;
    localparam int COEF_W   = 11;
    localparam int NUM_CH   = 5;
    localparam int REG_W    = 8;
    localparam logic [REG_W-1:0] REG_BASE = 8'hB3;
    localparam int LOW_W    = COEF_W - REG_W;
endpackage

// File: rtl/hpf_regs.sv
module hpf_regs
    import hpf_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = COEF_W,
    parameter logic [REG_W-1:0] BASE = REG_BASE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_W-1:0]     waddr,
    input  logic [REG_W-1:0]     wdata,
    input  logic [REG_W-1:0]     raddr,
    output logic [REG_W-1:0]     rdata,
    output logic [NCH*CW-1:0]    coef_o,
    output logic [NCH-1:0]       en_o
);
    localparam int LW = CW - REG_W;
    localparam logic [REG_W-1:0] EN_ADDR = REG_W'(BASE + 2*NCH);

    logic [REG_W-1:0] hi_q   [NCH];
    logic [LW-1:0]    lo_q   [NCH];
    logic [CW-1:0]    coef_q [NCH];
    logic [NCH-1:0]   en_q;

    // upper byte stages, low part commits the pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) begin
                hi_q[n]   <= '0;
                lo_q[n]   <= '0;
                coef_q[n] <= '0;
            end
            en_q <= '0;
        end else if (we) begin
            for (int n = 0; n < NCH; n++) begin
                if (waddr == REG_W'(BASE + 2*n))
                    hi_q[n] <= wdata;
                if (waddr == REG_W'(BASE + 2*n + 1)) begin
                    lo_q[n]   <= wdata[LW-1:0];
                    coef_q[n] <= {hi_q[n], wdata[LW-1:0]};
                end
            end
            if (waddr == EN_ADDR)
                en_q <= wdata[NCH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (raddr == REG_W'(BASE + 2*n))
                rdata = hi_q[n];
            if (raddr == REG_W'(BASE + 2*n + 1))
                rdata = {{(REG_W-LW){1'b0}}, lo_q[n]};
        end
        if (raddr == EN_ADDR)
            rdata = {{(REG_W-NCH){1'b0}}, en_q};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign coef_o[g*CW +: CW] = coef_q[g];
    end
    assign en_o = en_q;
endmodule

// File: rtl/hpf_chan.sv
module hpf_chan #(
    parameter int DW = 24,
    parameter int CW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic                 enable,
    input  logic [CW-1:0]        coef,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y
);
    localparam int AW    = DW + CW + 5;
    localparam int SHIFT = CW + 1;
    localparam logic signed [AW-1:0] RND    = {{(AW-CW-1){1'b0}}, 1'b1, {CW{1'b0}}};
    localparam logic signed [AW-1:0] SAT_HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW-1:0] xp_q, yp_q, y_next;
    logic signed [AW-1:0] diff, gain, fb, acc, scaled;

    always_comb begin
        diff   = AW'(x) - AW'(xp_q);
        gain   = {{(AW-CW-1){1'b0}}, 1'b1, coef};   // 2048 + c
        fb     = {{(AW-CW-1){1'b0}}, coef, 1'b0};   // 2c
        acc    = gain * diff + fb * AW'(yp_q) + RND;
        scaled = acc >>> SHIFT;
        if (scaled > SAT_HI)
            y_next = SAT_HI[DW-1:0];
        else if (scaled < SAT_LO)
            y_next = SAT_LO[DW-1:0];
        else
            y_next = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xp_q <= '0;
            yp_q <= '0;
            y    <= '0;
        end else if (!enable) begin
            xp_q <= '0;
            yp_q <= '0;
            if (smp_valid)
                y <= x;
        end else if (smp_valid) begin
            xp_q <= x;
            yp_q <= y_next;
            y    <= y_next;
        end
    end
endmodule

// File: rtl/hpf_bank.sv
module hpf_bank
    import hpf_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int DW  = SAMPLE_W,
    parameter int CW  = COEF_W,
    parameter logic [REG_W-1:0] BASE = REG_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [REG_W-1:0]   reg_raddr,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               in_valid,
    input  logic [NCH*DW-1:0]  in_data,
    output logic               out_valid,
    output logic [NCH*DW-1:0]  out_data
);
    logic [NCH*CW-1:0] chan_coef;
    logic [NCH-1:0]    chan_en;

    hpf_regs #(.NCH(NCH), .CW(CW), .BASE(BASE)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .waddr  (reg_addr),
        .wdata  (reg_wdata),
        .raddr  (reg_raddr),
        .rdata  (reg_rdata),
        .coef_o (chan_coef),
        .en_o   (chan_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        hpf_chan #(.DW(DW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (in_valid),
            .enable    (chan_en[g]),
            .coef      (chan_coef[g*CW +: CW]),
            .x         (in_data[g*DW +: DW]),
            .y         (out_data[g*DW +: DW])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end
endmodule

// File: rtl/hpf_bank_chk.sv
module hpf_bank_chk #(
    parameter int NCH = 5,
    parameter int DW  = 24,
    parameter int CW  = 11,
    parameter logic [7:0] BASE = 8'hB3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [NCH*DW-1:0] in_data,
    input logic              out_valid,
    input logic [NCH*DW-1:0] out_data,
    input logic [NCH-1:0]    chan_en,
    input logic [7:0]        reg_raddr,
    input logic [7:0]        reg_rdata
);
    localparam int LW = CW - 8;
    localparam logic [7:0] EN_ADDR = 8'(BASE + 2*NCH);

    logic is_low;
    always_comb begin
        is_low = 1'b0;
        for (int n = 0; n < NCH; n++)
            if (reg_raddr == 8'(BASE + 2*n + 1)) is_low = 1'b1;
    end

    // R8
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R3
    low_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_low |-> reg_rdata[7:LW] == '0);
    // R3
    en_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_raddr == EN_ADDR) |-> reg_rdata[7:NCH] == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_byp
        // R7
        bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !chan_en[g]) |=> out_data[g*DW +: DW] == $past(in_data[g*DW +: DW]));
    end
endmodule

bind hpf_bank hpf_bank_chk #(.NCH(NCH), .DW(DW), .CW(CW), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .chan_en   (chan_en),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata)
);

// File: tb/tb_hpf_bank.sv
`timescale 1ns/1ps
module tb_hpf_bank;
    localparam int NCH = 5;
    localparam int DW  = 24;

    logic clk = 1'b0;
    logic rst_n;
    logic reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_raddr, reg_rdata;
    logic in_valid, out_valid;
    logic [NCH*DW-1:0] in_data, out_data;

    always #10 clk = ~clk;

    hpf_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int chk = 0;
    int err = 0;
    logic [DW-1:0] xin  [NCH];
    logic [DW-1:0] expv [NCH];
    longint mxp [NCH];
    longint myp [NCH];
    int mcoef [NCH];
    int mstage [NCH];
    logic [NCH-1:0] men;
    logic pend_v;
    string pend_tag;

    function automatic longint fstep(longint c, longint d, longint yp);
        longint acc;
        acc = (2048 + c) * d + 2 * c * yp + 2048;
        acc = acc >>> 12;
        if (acc > 8388607)  return 8388607;
        if (acc < -8388608) return -8388608;
        return acc;
    endfunction

    task automatic check_outputs();
        chk++;
        if (out_valid !== pend_v) begin
            err++;
            $display("FAIL R8 out_valid got %0b exp %0b", out_valid, pend_v);
        end
        for (int ch = 0; ch < NCH; ch++) begin
            chk++;
            if (out_data[ch*DW +: DW] !== expv[ch]) begin
                err++;
                $display("FAIL %s ch%0d got %0d exp %0d", pend_tag, ch,
                         $signed(out_data[ch*DW +: DW]), $signed(expv[ch]));
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_outputs();
        in_valid = 1'b0;
        reg_we   = 1'b0;
        pend_v   = 1'b0;
        pend_tag = "R8";
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        int idx;
        tick();
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a >= 8'hB3 && a < 8'hBD) begin
            idx = (int'(a) - 'hB3) / 2;
            if (((int'(a) - 'hB3) % 2) == 0) mstage[idx] = int'(d);
            else mcoef[idx] = mstage[idx] * 8 + int'(d[2:0]);
        end else if (a == 8'hBD) begin
            men = d[NCH-1:0];
            for (int ch = 0; ch < NCH; ch++)
                if (!men[ch]) begin mxp[ch] = 0; myp[ch] = 0; end
        end
    endtask

    task automatic set_coef(input int ch, input int code);
        wr(8'(8'hB3 + 2*ch), 8'(code >> 3));
        wr(8'(8'hB4 + 2*ch), 8'(code & 7));
    endtask

    task automatic sample(input string tag);
        longint xv, y;
        tick();
        for (int ch = 0; ch < NCH; ch++) begin
            in_data[ch*DW +: DW] = xin[ch];
            xv = longint'($signed(xin[ch]));
            if (men[ch]) begin
                y = fstep(mcoef[ch], xv - mxp[ch], myp[ch]);
                mxp[ch] = xv; myp[ch] = y;
                expv[ch] = DW'(y);
            end else begin
                expv[ch] = xin[ch];
                mxp[ch] = 0; myp[ch] = 0;
            end
        end
        in_valid = 1'b1;
        pend_v = 1'b1;
        pend_tag = tag;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        reg_raddr = a;
        #1;
        chk++;
        if (reg_rdata !== e) begin
            err++;
            $display("FAIL %s read 0x%0h got 0x%0h exp 0x%0h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic lit(input int ch, input longint e, input string tag);
        chk++;
        if (longint'($signed(out_data[ch*DW +: DW])) != e) begin
            err++;
            $display("FAIL %s ch%0d got %0d exp %0d", tag, ch,
                     $signed(out_data[ch*DW +: DW]), e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        err++;
        $display("FAIL R8 watchdog expired got 0 exp 1");
        $display("  CHECKS %0d ERRORS %0d", chk, err);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        reg_raddr = '0; in_valid = 1'b0; in_data = '0;
        pend_v = 1'b0; pend_tag = "R1"; men = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            xin[ch] = '0; expv[ch] = '0; mxp[ch] = 0; myp[ch] = 0;
            mcoef[ch] = 0; mstage[ch] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check_outputs();
        for (int a = 'hB3; a <= 'hBD; a++) rd(8'(a), 8'h00, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 unmapped addresses ignored
        wr(8'hB2, 8'hFF);
        wr(8'hBE, 8'hFF);
        tick();
        rd(8'hB2, 8'h00, "R2");
        rd(8'hBE, 8'h00, "R2");
        for (int a = 'hB3; a <= 'hBD; a++) rd(8'(a), 8'h00, "R2");

        // R3 padding bits dropped
        for (int a = 'hB3; a <= 'hBD; a++) wr(8'(a), 8'hFF);
        tick();
        for (int ch = 0; ch < NCH; ch++) begin
            rd(8'(8'hB3 + 2*ch), 8'hFF, "R2");
            rd(8'(8'hB4 + 2*ch), 8'h07, "R3");
        end
        rd(8'hBD, 8'h1F, "R3");

        // R10 DC rejection at code 1820
        wr(8'hBD, 8'h00);
        for (int ch = 0; ch < NCH; ch++) set_coef(ch, 1820);
        wr(8'hBD, 8'h1F);
        for (int ch = 0; ch < NCH; ch++) xin[ch] = 24'd1000000;
        sample("R10");
        tick();
        lit(0, 944336, "R10");
        for (int i = 0; i < 300; i++) sample("R10");
        tick();
        for (int ch = 0; ch < NCH; ch++) begin
            chk++;
            if ($signed(out_data[ch*DW +: DW]) > 8 || $signed(out_data[ch*DW +: DW]) < -8) begin
                err++;
                $display("FAIL R10 ch%0d got %0d exp within 8 of 0", ch,
                         $signed(out_data[ch*DW +: DW]));
            end
        end

        // R4 upper byte alone does not change the active code
        wr(8'hB5, 8'h00);
        for (int ch = 0; ch < NCH; ch++) xin[ch] = 24'h400000;
        sample("R4");
        sample("R4");
        wr(8'hB6, 8'h03);
        tick();
        rd(8'hB5, 8'h00, "R4");
        sample("R4");

        // R9 distinct codes, one shared input step
        set_coef(0, 0); set_coef(1, 2047); set_coef(2, 512);
        set_coef(3, 1024); set_coef(4, 1536);
        wr(8'hBD, 8'h00);
        wr(8'hBD, 8'h1F);
        for (int ch = 0; ch < NCH; ch++) xin[ch] = 24'(ch * 300000 - 600000);
        sample("R9");
        sample("R9");

        // R6 positive saturation with code 0
        wr(8'hBD, 8'h00);
        wr(8'hBD, 8'h01);
        xin[0] = 24'h800000;
        sample("R6");
        xin[0] = 24'h7FFFFF;
        sample("R6");
        tick();
        lit(0, 8388607, "R6");

        // R7 bypass and fresh start after re-enable
        wr(8'hBD, 8'h1B);
        for (int ch = 0; ch < NCH; ch++) xin[ch] = 24'($urandom);
        sample("R7");
        tick();
        lit(2, longint'($signed(xin[2])), "R7");
        wr(8'hBD, 8'h1F);
        sample("R7");

        // R5 random codes, enables, samples and strobe gaps
        for (int i = 0; i < 800; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) wr(8'hBD, 8'($urandom));
            else if (r == 1) wr(8'(8'hB3 + 2 * ($urandom % NCH)), 8'($urandom));
            else if (r == 2) wr(8'(8'hB4 + 2 * ($urandom % NCH)), 8'($urandom));
            else if (r < 6) tick();
            else begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if ($urandom % 8 == 0) xin[ch] = ($urandom % 2) ? 24'h7FFFFF : 24'h800000;
                    else xin[ch] = 24'($urandom);
                end
                sample("R5");
            end
        end
        tick();

        $display("  CHECKS %0d ERRORS %0d", chk, err);
        $finish;
    end
endmodule